// File: doc/BRIEF.md
# Descriptor Chain Walker

This block walks a ring of transfer descriptors in memory for a single DMA channel. Each descriptor sits on a 64-byte boundary. It holds a link to the next descriptor, a buffer address, a control word and a status word. The walker reads these words over a simple word-wide memory port that has a request/acknowledge handshake. It decodes the buffer address, the byte length and the frame-boundary flags, and passes the request to a data mover. When the mover reports back, the walker writes a status word into the descriptor that records the transferred byte count and the completion or error bits.

Software programs a start pointer while the channel is halted, then writes a tail pointer. The walker follows the links until the descriptor at the tail has been written back, then goes idle. A later tail write resumes at the next descriptor in the ring. Any memory error response, any descriptor that is already marked complete outside cyclic mode, a zero-length descriptor and any mover error all stop the walker. It then stays halted until reset. Words other than the status word are never written, so the application words that follow it pass through untouched.

Top module: `sgw_walker`

## Requirements
- R1: After reset the walker reports halted, not idle. It drives no memory or mover request, and both error vectors are zero.
- R2: A start-pointer write takes effect only in the halted state before the first start, and its low 6 bits are ignored. A start-pointer write while idle has no effect on the next descriptor fetched.
- R3: For each descriptor the walker reads four words, in this order, at byte offsets 0x00 (link), 0x08 (buffer address), 0x18 (control) and 0x1C (status) from the descriptor base. It holds each request until it is acknowledged.
- R4: The mover request carries the buffer address word, the length from control bits 25:0, start-of-frame from control bit 27 and end-of-frame from control bit 26. Control bits 31:28 are ignored.
- R5: After a successful move the walker issues exactly one write, at offset 0x1C. The written word has bit 31 set, bits 30:26 clear and the mover's reported byte count in bits 25:0. No other descriptor word is written.
- R6: The next descriptor base is the link word with its low 6 bits cleared. After the descriptor whose base equals the tail pointer is written back, the walker becomes idle.
- R7: A tail write while idle restarts the walk at the link of the last completed descriptor.
- R8: With cyclic mode off, a fetched status word whose bit 31 is set raises the scatter-gather internal error (bit 0 of the scatter-gather error vector). No mover request and no write-back follow, and the walker halts.
- R9: With cyclic mode on, a descriptor whose status bit 31 is already set is processed like any other.
- R10: A descriptor with length zero is never sent to the mover. Its status is written as 0x1000_0000 (internal error, bit 28). Bit 0 of the transfer error vector is set and the walker halts.
- R11: Memory responses are 00/01 okay, 10 slave error and 11 decode error. An error response on any descriptor access sets bit 1 (slave) or bit 2 (decode) of the scatter-gather error vector and halts the walker, with no further accesses.
- R12: A mover response of slave error (10) or decode error (11) writes status bit 31, plus bit 29 (slave) or bit 30 (decode), plus the count. It then sets bit 1 or bit 2 of the transfer error vector and halts.
- R13: Once either error vector is non-zero, it holds its value and the walker stays halted until reset. Tail writes start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyclic_en | input | 1 | Accept descriptors already marked complete |
| cur_wr | input | 1 | Start-pointer write strobe |
| cur_wdata | input | ADDR_W | Start-pointer value |
| tail_wr | input | 1 | Tail-pointer write strobe; starts or resumes the walk |
| tail_wdata | input | ADDR_W | Tail-pointer value |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | WORD_W | Write data |
| mem_ack | input | 1 | Access completed |
| mem_resp | input | 2 | Access response code |
| mem_rdata | input | WORD_W | Read data, valid with mem_ack |
| mv_req | output | 1 | Transfer request to the mover, held until done |
| mv_addr | output | ADDR_W | Buffer address |
| mv_len | output | LEN_W | Buffer length in bytes |
| mv_sof | output | 1 | Buffer starts a frame |
| mv_eof | output | 1 | Buffer ends a frame |
| mv_done | input | 1 | Mover finished |
| mv_resp | input | 2 | Mover response code |
| mv_count | input | LEN_W | Bytes actually transferred |
| st_idle | output | 1 | Walk finished at tail; waiting for tail write |
| st_halted | output | 1 | Halted (after reset or after an error) |
| sg_err | output | 3 | Descriptor-access errors {decode, slave, internal} |
| xfer_err | output | 3 | Transfer errors {decode, slave, internal} |

## Verification
The hardest state to reach is the resume from idle. The walker must begin at the link saved from the previous tail descriptor and ignore a start pointer written in between. The bench first runs a three-descriptor chain whose links carry junk in their low bits. While the walker is idle it writes a misleading start pointer, then a new tail, and checks the first fetched address. The same ring then serves the cyclic case, because the descriptor that comes next already carries the complete bit from the earlier pass. The error paths each use a fresh reset, and the memory model injects responses at chosen addresses.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   localparam int DESC_ALIGN = 6;

   localparam logic [DESC_ALIGN-1:0] OFF_LINK = 6'h00;
   localparam logic [DESC_ALIGN-1:0] OFF_BUF  = 6'h08;
   localparam logic [DESC_ALIGN-1:0] OFF_CTL  = 6'h18;
   localparam logic [DESC_ALIGN-1:0] OFF_STS  = 6'h1C;

   localparam int FIELD_LEN_W = 26;
   localparam int BIT_SOF     = 27;
   localparam int BIT_EOF     = 26;
   localparam int BIT_CMPL    = 31;
   localparam int BIT_DECE    = 30;
   localparam int BIT_SLVE    = 29;
   localparam int BIT_INTE    = 28;

   typedef enum logic [1:0] {
      RESP_OK   = 2'b00,
      RESP_EXOK = 2'b01,
      RESP_SLV  = 2'b10,
      RESP_DEC  = 2'b11
   } resp_e;

   typedef enum logic [3:0] {
      ST_HALT, ST_IDLE, ST_LINK, ST_BUF, ST_CTL, ST_STS,
      ST_CHK, ST_MOVE, ST_WB, ST_ERR
   } walk_state_e;

   typedef struct packed {
      logic dec;
      logic slv;
      logic intl;
   } errv_t;

endpackage

// File: rtl/sgw_ptr_bank.sv
module sgw_ptr_bank #(
   parameter int HI_W = 26
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cur_ld,
   input  logic [HI_W-1:0] cur_in,
   input  logic            tail_ld,
   input  logic [HI_W-1:0] tail_in,
   input  logic            adv,
   input  logic [HI_W-1:0] adv_in,
   output logic [HI_W-1:0] cur_base,
   output logic            at_tail
);

   logic [HI_W-1:0] cur_q;
   logic [HI_W-1:0] tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         tail_q <= '0;
      end else begin
         if (cur_ld)
            cur_q <= cur_in;
         else if (adv)
            cur_q <= adv_in;
         if (tail_ld)
            tail_q <= tail_in;
      end
   end

   assign cur_base = cur_q;
   assign at_tail  = (cur_q == tail_q);

endmodule

// File: rtl/sgw_word_decode.sv
module sgw_word_decode
   import sgw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int LEN_W  = 26
) (
   input  logic [WORD_W-1:0] buf_w,
   input  logic [WORD_W-1:0] ctl_w,
   input  logic [WORD_W-1:0] sts_w,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [LEN_W-1:0]  len,
   output logic              sof,
   output logic              eof,
   output logic              already_done,
   output logic              len_zero
);

   assign len          = ctl_w[LEN_W-1:0];
   assign sof          = ctl_w[BIT_SOF];
   assign eof          = ctl_w[BIT_EOF];
   assign already_done = sts_w[BIT_CMPL];
   assign len_zero     = (len == '0);

   logic unused_fields;

   generate
      if (ADDR_W == WORD_W) begin : g_buf_full
         assign buf_addr = buf_w;
         if (LEN_W < FIELD_LEN_W) begin : g_len_narrow
            assign unused_fields = ^{ctl_w[WORD_W-1:BIT_SOF+1], ctl_w[FIELD_LEN_W-1:LEN_W],
                                     sts_w[BIT_CMPL-1:0]};
         end else begin : g_len_full
            assign unused_fields = ^{ctl_w[WORD_W-1:BIT_SOF+1], sts_w[BIT_CMPL-1:0]};
         end
      end else begin : g_buf_trunc
         assign buf_addr = buf_w[ADDR_W-1:0];
         if (LEN_W < FIELD_LEN_W) begin : g_len_narrow
            assign unused_fields = ^{buf_w[WORD_W-1:ADDR_W], ctl_w[WORD_W-1:BIT_SOF+1],
                                     ctl_w[FIELD_LEN_W-1:LEN_W], sts_w[BIT_CMPL-1:0]};
         end else begin : g_len_full
            assign unused_fields = ^{buf_w[WORD_W-1:ADDR_W], ctl_w[WORD_W-1:BIT_SOF+1],
                                     sts_w[BIT_CMPL-1:0]};
         end
      end
   endgenerate

endmodule

// File: rtl/sgw_status_pack.sv
module sgw_status_pack
   import sgw_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 26
) (
   input  logic [LEN_W-1:0]  count,
   input  logic [1:0]        resp,
   input  logic              zero_len,
   output logic [WORD_W-1:0] word
);

   always_comb begin
      word = '0;
      if (zero_len) begin
         word[BIT_INTE] = 1'b1;
      end else begin
         word[LEN_W-1:0] = count;
         word[BIT_CMPL]  = 1'b1;
         word[BIT_DECE]  = (resp_e'(resp) == RESP_DEC);
         word[BIT_SLVE]  = (resp_e'(resp) == RESP_SLV);
      end
   end

endmodule

// File: rtl/sgw_err_flags.sv
module sgw_err_flags
   import sgw_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  errv_t sg_set,
   input  errv_t xf_set,
   output errv_t sg_q,
   output errv_t xf_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sg_q <= '0;
         xf_q <= '0;
      end else begin
         sg_q <= sg_q | sg_set;
         xf_q <= xf_q | xf_set;
      end
   end

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int LEN_W  = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyclic_en,
   input  logic              cur_wr,
   input  logic [ADDR_W-1:0] cur_wdata,
   input  logic              tail_wr,
   input  logic [ADDR_W-1:0] tail_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [1:0]        mem_resp,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mv_req,
   output logic [ADDR_W-1:0] mv_addr,
   output logic [LEN_W-1:0]  mv_len,
   output logic              mv_sof,
   output logic              mv_eof,
   input  logic              mv_done,
   input  logic [1:0]        mv_resp,
   input  logic [LEN_W-1:0]  mv_count,
   output logic              st_idle,
   output logic              st_halted,
   output logic [2:0]        sg_err,
   output logic [2:0]        xfer_err
);

   localparam int HI_W = ADDR_W - DESC_ALIGN;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("sgw_walker: descriptor words must be 32 bits");
      end
      if (ADDR_W <= DESC_ALIGN || ADDR_W > WORD_W) begin : g_bad_addr
         $error("sgw_walker: ADDR_W must exceed the alignment and fit a word");
      end
      if (LEN_W < 1 || LEN_W > FIELD_LEN_W) begin : g_bad_len
         $error("sgw_walker: LEN_W out of range");
      end
   endgenerate

   walk_state_e       state_q, state_d;
   logic [HI_W-1:0]   link_q;
   logic [WORD_W-1:0] buf_q, ctl_q, sts_q, wb_q;
   errv_t             xerr_q;

   logic              cur_ld, tail_ld, adv, cap_wb, wb_zero;
   logic [HI_W-1:0]   cur_base;
   logic              at_tail;
   logic              resp_bad;
   errv_t             sg_set, xf_set, sg_q, xf_q;
   logic [LEN_W-1:0]  dec_len;
   logic              dec_sof, dec_eof, dec_done, dec_zero;
   logic [ADDR_W-1:0] dec_buf;
   logic [WORD_W-1:0] pack_word;
   logic [DESC_ALIGN-1:0] off;
   logic              unused_low;

   assign unused_low = ^{cur_wdata[DESC_ALIGN-1:0], tail_wdata[DESC_ALIGN-1:0]};

   sgw_ptr_bank #(.HI_W(HI_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_ld   (cur_ld),
      .cur_in   (cur_wdata[ADDR_W-1:DESC_ALIGN]),
      .tail_ld  (tail_ld),
      .tail_in  (tail_wdata[ADDR_W-1:DESC_ALIGN]),
      .adv      (adv),
      .adv_in   (link_q),
      .cur_base (cur_base),
      .at_tail  (at_tail)
   );

   sgw_word_decode #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_dec (
      .buf_w        (buf_q),
      .ctl_w        (ctl_q),
      .sts_w        (sts_q),
      .buf_addr     (dec_buf),
      .len          (dec_len),
      .sof          (dec_sof),
      .eof          (dec_eof),
      .already_done (dec_done),
      .len_zero     (dec_zero)
   );

   sgw_status_pack #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_pack (
      .count    (wb_zero ? '0 : mv_count),
      .resp     (wb_zero ? RESP_OK : mv_resp),
      .zero_len (wb_zero),
      .word     (pack_word)
   );

   sgw_err_flags u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .sg_set (sg_set),
      .xf_set (xf_set),
      .sg_q   (sg_q),
      .xf_q   (xf_q)
   );

   assign resp_bad = (resp_e'(mem_resp) == RESP_SLV) || (resp_e'(mem_resp) == RESP_DEC);

   always_comb begin
      state_d = state_q;
      sg_set  = '0;
      xf_set  = '0;
      adv     = 1'b0;
      cap_wb  = 1'b0;
      wb_zero = 1'b0;
      cur_ld  = cur_wr && (state_q == ST_HALT);
      tail_ld = tail_wr && (state_q != ST_ERR);

      if (mem_req && mem_ack && resp_bad) begin
         sg_set.dec = (resp_e'(mem_resp) == RESP_DEC);
         sg_set.slv = (resp_e'(mem_resp) == RESP_SLV);
      end

      unique case (state_q)
         ST_HALT, ST_IDLE: if (tail_wr) state_d = ST_LINK;
         ST_LINK: if (mem_ack) state_d = resp_bad ? ST_ERR : ST_BUF;
         ST_BUF:  if (mem_ack) state_d = resp_bad ? ST_ERR : ST_CTL;
         ST_CTL:  if (mem_ack) state_d = resp_bad ? ST_ERR : ST_STS;
         ST_STS:  if (mem_ack) state_d = resp_bad ? ST_ERR : ST_CHK;
         ST_CHK: begin
            if (dec_done && !cyclic_en) begin
               sg_set.intl = 1'b1;
               state_d     = ST_ERR;
            end else if (dec_zero) begin
               cap_wb  = 1'b1;
               wb_zero = 1'b1;
               state_d = ST_WB;
            end else begin
               state_d = ST_MOVE;
            end
         end
         ST_MOVE: if (mv_done) begin
            cap_wb  = 1'b1;
            state_d = ST_WB;
         end
         ST_WB: if (mem_ack) begin
            if (resp_bad) begin
               state_d = ST_ERR;
            end else if (xerr_q != '0) begin
               xf_set  = xerr_q;
               state_d = ST_ERR;
            end else begin
               adv     = 1'b1;
               state_d = at_tail ? ST_IDLE : ST_LINK;
            end
         end
         default: state_d = ST_ERR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HALT;
         link_q  <= '0;
         buf_q   <= '0;
         ctl_q   <= '0;
         sts_q   <= '0;
         wb_q    <= '0;
         xerr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (mem_ack && !resp_bad) begin
            if (state_q == ST_LINK) link_q <= mem_rdata[ADDR_W-1:DESC_ALIGN];
            if (state_q == ST_BUF)  buf_q  <= mem_rdata;
            if (state_q == ST_CTL)  ctl_q  <= mem_rdata;
            if (state_q == ST_STS)  sts_q  <= mem_rdata;
         end
         if (cap_wb) begin
            wb_q        <= pack_word;
            xerr_q.intl <= wb_zero;
            xerr_q.slv  <= !wb_zero && (resp_e'(mv_resp) == RESP_SLV);
            xerr_q.dec  <= !wb_zero && (resp_e'(mv_resp) == RESP_DEC);
         end
      end
   end

   always_comb begin
      unique case (state_q)
         ST_BUF:  off = OFF_BUF;
         ST_CTL:  off = OFF_CTL;
         ST_STS:  off = OFF_STS;
         ST_WB:   off = OFF_STS;
         default: off = OFF_LINK;
      endcase
   end

   assign mem_req   = (state_q == ST_LINK) || (state_q == ST_BUF) || (state_q == ST_CTL) ||
                      (state_q == ST_STS)  || (state_q == ST_WB);
   assign mem_we    = (state_q == ST_WB);
   assign mem_addr  = {cur_base, off};
   assign mem_wdata = wb_q;

   assign mv_req  = (state_q == ST_MOVE);
   assign mv_addr = dec_buf;
   assign mv_len  = dec_len;
   assign mv_sof  = dec_sof;
   assign mv_eof  = dec_eof;

   assign st_idle   = (state_q == ST_IDLE);
   assign st_halted = (state_q == ST_HALT) || (state_q == ST_ERR);
   assign sg_err    = sg_q;
   assign xfer_err  = xf_q;

endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
   parameter int LEN_W = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             mem_we,
   input logic [5:0]       mem_off,
   input logic             mem_ack,
   input logic [1:0]       wb_rsvd,
   input logic             mv_req,
   input logic [LEN_W-1:0] mv_len,
   input logic             st_idle,
   input logic             st_halted,
   input logic [2:0]       sg_err,
   input logic [2:0]       xfer_err
);

   // R3
   addr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_off == 6'h00 || mem_off == 6'h08 || mem_off == 6'h18 || mem_off == 6'h1C));

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_off)));

   // R5
   wb_status_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_off == 6'h1C && wb_rsvd == 2'b00));

   // R10
   mv_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req |-> (mv_len != '0));

   // R4
   mv_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req |-> !mem_req);

   // R6
   idle_halt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_idle && st_halted));

   // R13
   err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sg_err != 3'b000) || (xfer_err != 3'b000)) |-> (st_halted && !mem_req && !mv_req));

   // R13
   sg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sg_err != 3'b000) |=> (sg_err == $past(sg_err)));

   // R13
   xf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_err != 3'b000) |=> (xfer_err == $past(xfer_err)));

endmodule

bind sgw_walker sgw_walker_chk #(.LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_off   (mem_addr[5:0]),
   .mem_ack   (mem_ack),
   .wb_rsvd   (mem_wdata[27:26]),
   .mv_req    (mv_req),
   .mv_len    (mv_len),
   .st_idle   (st_idle),
   .st_halted (st_halted),
   .sg_err    (sg_err),
   .xfer_err  (xfer_err)
);

// File: tb/sgw_walker_bench.sv
`timescale 1ns/1ps
module sgw_walker_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        cyclic_en = 1'b0;
   logic        cur_wr = 1'b0;
   logic [31:0] cur_wdata = '0;
   logic        tail_wr = 1'b0;
   logic [31:0] tail_wdata = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [1:0]  mem_resp = 2'b00;
   logic [31:0] mem_rdata = '0;
   logic        mv_req;
   logic [31:0] mv_addr;
   logic [25:0] mv_len;
   logic        mv_sof, mv_eof;
   logic        mv_done = 1'b0;
   logic [1:0]  mv_resp = 2'b00;
   logic [25:0] mv_count = '0;
   logic        st_idle, st_halted;
   logic [2:0]  sg_err, xfer_err;

   sgw_walker u_sgw_walker (
      .clk(clk), .rst_n(rst_n), .cyclic_en(cyclic_en),
      .cur_wr(cur_wr), .cur_wdata(cur_wdata), .tail_wr(tail_wr), .tail_wdata(tail_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_resp(mem_resp), .mem_rdata(mem_rdata),
      .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_sof(mv_sof), .mv_eof(mv_eof),
      .mv_done(mv_done), .mv_resp(mv_resp), .mv_count(mv_count),
      .st_idle(st_idle), .st_halted(st_halted), .sg_err(sg_err), .xfer_err(xfer_err)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // memory model state
   logic [31:0] mem [0:255];
   logic        inj_en = 1'b0;
   logic [31:0] inj_addr = '0;
   logic [1:0]  inj_resp = 2'b00;
   logic [31:0] log_addr [0:31];
   logic        log_we   [0:31];
   int          log_n = 0;

   // mover model state
   logic        mv_busy = 1'b0;
   int          mv_dly = 0;
   logic [25:0] cap_len = '0;
   logic [25:0] mv_short = '0;
   logic [1:0]  mv_err_resp = 2'b00;
   logic [31:0] mvl_addr [0:7];
   logic [25:0] mvl_len  [0:7];
   logic        mvl_sof  [0:7];
   logic        mvl_eof  [0:7];
   int          mvl_n = 0;

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         mem_resp = (inj_en && mem_addr == inj_addr) ? inj_resp : 2'b00;
         if (log_n < 32) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n]   = mem_we;
         end
         log_n = log_n + 1;
         if (mem_we && mem_resp == 2'b00) mem[mem_addr[9:2]] = mem_wdata;
         mem_rdata = mem[mem_addr[9:2]];
         mem_ack   = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (mv_done) begin
         mv_done = 1'b0;
         mv_busy = 1'b0;
      end else if (mv_req && !mv_busy) begin
         mv_busy = 1'b1;
         mv_dly  = 2;
         cap_len = mv_len;
         if (mvl_n < 8) begin
            mvl_addr[mvl_n] = mv_addr;
            mvl_len[mvl_n]  = mv_len;
            mvl_sof[mvl_n]  = mv_sof;
            mvl_eof[mvl_n]  = mv_eof;
         end
         mvl_n = mvl_n + 1;
      end else if (mv_busy) begin
         if (mv_dly == 0) begin
            mv_done  = 1'b1;
            mv_count = cap_len - mv_short;
            mv_resp  = mv_err_resp;
         end else begin
            mv_dly = mv_dly - 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int base, input logic [31:0] lnk, input logic [31:0] bufa,
                           input logic [31:0] ctl, input logic [31:0] sts);
      mem[base/4 + 0] = lnk;
      mem[base/4 + 2] = bufa;
      mem[base/4 + 6] = ctl;
      mem[base/4 + 7] = sts;
      mem[base/4 + 8] = 32'hA5A5_0000 + base;
   endtask

   task automatic clear_logs();
      log_n = 0;
      mvl_n = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      inj_en = 1'b0;
      mv_short = '0;
      mv_err_resp = 2'b00;
      cyclic_en = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clear_logs();
   endtask

   task automatic load_cur(input logic [31:0] a);
      @(negedge clk);
      cur_wdata = a;
      cur_wr = 1'b1;
      @(negedge clk);
      cur_wr = 1'b0;
   endtask

   task automatic write_tail(input logic [31:0] a);
      @(negedge clk);
      tail_wdata = a;
      tail_wr = 1'b1;
      @(negedge clk);
      tail_wr = 1'b0;
   endtask

   task automatic wait_settle();
      for (int i = 0; i < 400; i++) begin
         if (st_idle || st_halted) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic check_desc_trace(input string tag, input int first, input logic [31:0] base);
      chk({tag, " link read"},   log_addr[first],   base + 32'h00);
      chk({tag, " buf read"},    log_addr[first+1], base + 32'h08);
      chk({tag, " ctl read"},    log_addr[first+2], base + 32'h18);
      chk({tag, " status read"}, log_addr[first+3], base + 32'h1C);
      chk({tag, " wb addr"},     log_addr[first+4], base + 32'h1C);
      chk({tag, " wb is write"}, {31'b0, log_we[first+4]}, 32'd1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 halted", {31'b0, st_halted}, 32'd1);
      chk("R1 idle", {31'b0, st_idle}, 32'd0);
      chk("R1 no requests", {30'b0, mem_req, mv_req}, 32'd0);
      chk("R1 errors clear", {26'b0, sg_err, xfer_err}, 32'd0);
   endtask

   task automatic t_chain();
      put_desc(32'h000, 32'h0000_0040, 32'h2000_0000, 32'h0C00_0010, 32'h0);
      put_desc(32'h040, 32'h0000_0085, 32'h1000_0000, 32'h0800_0064, 32'h0);
      put_desc(32'h080, 32'h0000_00C0, 32'h1000_4000, 32'hF000_00C8, 32'h0);
      put_desc(32'h0C0, 32'h0000_0000, 32'h1000_8000, 32'h07FF_FFFF, 32'h0);
      load_cur(32'h0000_0043);
      write_tail(32'h0000_00C0);
      wait_settle();
      chk("R6 idle at tail", {30'b0, st_idle, st_halted}, 32'd2);
      chk("R3 access count", log_n, 32'd15);
      check_desc_trace("R2 R3 desc1", 0, 32'h040);
      check_desc_trace("R6 desc2", 5, 32'h080);
      check_desc_trace("R6 desc3", 10, 32'h0C0);
      chk("R4 move count", mvl_n, 32'd3);
      chk("R4 addr1", mvl_addr[0], 32'h1000_0000);
      chk("R4 len1", {6'b0, mvl_len[0]}, 32'd100);
      chk("R4 flags1", {30'b0, mvl_sof[0], mvl_eof[0]}, 32'd2);
      chk("R4 len2 rsvd ignored", {6'b0, mvl_len[1]}, 32'd200);
      chk("R4 flags2", {30'b0, mvl_sof[1], mvl_eof[1]}, 32'd0);
      chk("R4 len3 max", {6'b0, mvl_len[2]}, 32'h03FF_FFFF);
      chk("R4 flags3", {30'b0, mvl_sof[2], mvl_eof[2]}, 32'd1);
      chk("R5 status1", mem[32'h05C/4], 32'h8000_0064);
      chk("R5 status2", mem[32'h09C/4], 32'h8000_00C8);
      chk("R5 status3", mem[32'h0DC/4], 32'h83FF_FFFF);
      chk("R5 ctl untouched", mem[32'h098/4], 32'hF000_00C8);
      chk("R5 user word untouched", mem[32'h060/4], 32'hA5A5_0040);
      chk("R5 desc0 untouched", mem[32'h01C/4], 32'h0);
   endtask

   task automatic t_resume();
      clear_logs();
      mv_short = 26'd2;
      load_cur(32'h0000_0200);
      write_tail(32'h0000_0000);
      wait_settle();
      chk("R7 R2 resume addr", log_addr[0], 32'h0);
      chk("R7 access count", log_n, 32'd5);
      chk("R5 count from mover", mem[32'h01C/4], 32'h8000_000E);
      chk("R7 idle again", {31'b0, st_idle}, 32'd1);
      mv_short = '0;
   endtask

   task automatic t_cyclic();
      clear_logs();
      mem[32'h058/4] = 32'h0C00_0030;
      cyclic_en = 1'b1;
      write_tail(32'h0000_0040);
      wait_settle();
      chk("R9 moved", mvl_n, 32'd1);
      chk("R9 status rewritten", mem[32'h05C/4], 32'h8000_0030);
      chk("R9 idle", {31'b0, st_idle}, 32'd1);
      chk("R9 no error", {26'b0, sg_err, xfer_err}, 32'd0);
      cyclic_en = 1'b0;
   endtask

   task automatic t_done_reject();
      do_reset();
      put_desc(32'h000, 32'h0, 32'h3000_0000, 32'h0C00_0008, 32'h8000_0005);
      load_cur(32'h0);
      write_tail(32'h0);
      wait_settle();
      chk("R8 sg internal", {29'b0, sg_err}, 32'd1);
      chk("R8 xfer clear", {29'b0, xfer_err}, 32'd0);
      chk("R8 halted", {31'b0, st_halted}, 32'd1);
      chk("R8 no move", mvl_n, 32'd0);
      chk("R8 reads only", log_n, 32'd4);
      chk("R8 status kept", mem[32'h01C/4], 32'h8000_0005);
      write_tail(32'h0);
      repeat (20) @(negedge clk);
      chk("R13 no access after error", log_n, 32'd4);
      chk("R13 still halted", {30'b0, st_halted, st_idle}, 32'd2);
      chk("R13 flag held", {29'b0, sg_err}, 32'd1);
   endtask

   task automatic t_zero_len();
      do_reset();
      put_desc(32'h000, 32'h0, 32'h3000_0000, 32'h0C00_0000, 32'h0);
      load_cur(32'h0);
      write_tail(32'h0);
      wait_settle();
      chk("R10 status word", mem[32'h01C/4], 32'h1000_0000);
      chk("R10 xfer internal", {29'b0, xfer_err}, 32'd1);
      chk("R10 no move", mvl_n, 32'd0);
      chk("R10 halted", {31'b0, st_halted}, 32'd1);
   endtask

   task automatic t_fetch_err();
      do_reset();
      put_desc(32'h000, 32'h0, 32'h3000_0000, 32'h0C00_0008, 32'h0);
      inj_en = 1'b1; inj_addr = 32'h008; inj_resp = 2'b10;
      load_cur(32'h0);
      write_tail(32'h0);
      wait_settle();
      chk("R11 sg slave", {29'b0, sg_err}, 32'd2);
      chk("R11 stop after bad read", log_n, 32'd2);
      chk("R11 halted", {31'b0, st_halted}, 32'd1);
      do_reset();
      put_desc(32'h000, 32'h0, 32'h3000_0000, 32'h0C00_0008, 32'h0);
      inj_en = 1'b1; inj_addr = 32'h01C; inj_resp = 2'b11;
      load_cur(32'h0);
      write_tail(32'h0);
      wait_settle();
      chk("R11 sg decode", {29'b0, sg_err}, 32'd4);
      chk("R11 decode stop", log_n, 32'd4);
      chk("R11 no move", mvl_n, 32'd0);
   endtask

   task automatic t_mover_err();
      do_reset();
      put_desc(32'h000, 32'h0, 32'h3000_0000, 32'h0C00_0040, 32'h0);
      mv_err_resp = 2'b10; mv_short = 26'd4;
      load_cur(32'h0);
      write_tail(32'h0);
      wait_settle();
      chk("R12 slave status", mem[32'h01C/4], 32'hA000_003C);
      chk("R12 xfer slave", {29'b0, xfer_err}, 32'd2);
      chk("R12 halted", {31'b0, st_halted}, 32'd1);
      do_reset();
      put_desc(32'h000, 32'h0, 32'h3000_0000, 32'h0C00_0040, 32'h0);
      mv_err_resp = 2'b11; mv_short = 26'd4;
      load_cur(32'h0);
      write_tail(32'h0);
      wait_settle();
      chk("R12 decode status", mem[32'h01C/4], 32'hC000_003C);
      chk("R12 xfer decode", {29'b0, xfer_err}, 32'd4);
      chk("R12 sg clear", {29'b0, sg_err}, 32'd0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_chain();
      t_resume();
      t_cyclic();
      t_done_reject();
      t_zero_len();
      t_fetch_err();
      t_mover_err();
      summary();
      $finish;
   end

endmodule